// File: doc/BRIEF.md
# Function Event Record Queue

This block holds pending function events for up to 32 device slots in a first-in first-out queue and hands them to a reader one at a time. The queue has two producers. An external port pushes either an error event or an availability event. A per-slot plug/unplug sequencer pushes the fixed availability events that a slot state change requires. Each stored event carries a class code, a function ID, a function handle and a 16-bit event code. Error events also carry a 64-bit faulting address and a 32-bit qualifier word.

The reader always sees the oldest entry as a packed 26-byte record. Multi-byte fields in the record are big-endian, and byte k of the record sits on bits [8k+7:8k]. A pop removes that entry. The host sees a level that is high while anything is pending. It also sees a one-cycle notification pulse after every accepted push, and a sticky flag that records any event lost because the queue was full.

Top module: `fn_event_queue`

## Requirements
- R1: The class byte (record byte 2) is 1 for an error event and 2 for an availability event. An external push whose class is 0 or 3 is ignored: nothing is stored, there is no notification pulse and the overflow flag does not change.
- R2: An error record holds the function ID in bytes 4..7, the function handle in bytes 8..11, the qualifier in bytes 12..15, the faulting address in bytes 16..23 and the event code in bytes 24..25. Every multi-byte field is big-endian, with its most significant byte at the lowest byte index.
- R3: An availability record uses the same layout as an error record. Its qualifier and address bytes are zero whatever values were pushed.
- R4: Events leave in arrival order and a pop removes the oldest one. A push and a pop in the same cycle are both honoured, and this includes a full queue, where the pop frees the room for the push.
- R5: `have_event_o` is high exactly when the queue holds at least one entry. It reflects a push or pop from the cycle after the clock edge that takes it.
- R6: `notify_o` is high for one cycle after every clock edge at which at least one push is stored.
- R7: A plug request for slot s stores two availability events in order: code 0x0301 (reserved to standby) and then code 0x0302 (standby to configured). Both carry function ID s and handle s with bit 31 set. The request marks slot s as configured.
- R8: An unplug request for a configured slot stores code 0x0303 (configured to standby/reserved), then code 0x0304 (standby to reserved), and clears the configured mark. An unplug request for an unconfigured slot stores only code 0x0304.
- R9: Whenever the queue is non-empty, record bytes 0..1 hold the big-endian record length 26 (0x00, 0x1A) and byte 3 is zero.
- R10: A push that finds no room is dropped and sets `overflow_o`, which stays high until reset.
- R11: While the queue is empty, the record is all zero (so the class is 0), and a pop changes nothing.
- R12: Pushes in one cycle are ordered sequencer events first, then the external event, and each push takes a free entry in that order. If plug and unplug are requested together, the plug is performed and the unplug is ignored.
- R13: After reset the queue is empty, `notify_o` and `overflow_o` are low, and every slot is unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | External event push strobe |
| push_class_i | input | 2 | Event class: 1 error, 2 availability |
| push_fid_i | input | 32 | Function ID |
| push_fh_i | input | 32 | Function handle |
| push_code_i | input | 16 | Event code |
| push_addr_i | input | 64 | Faulting address (error events only) |
| push_qual_i | input | 32 | Error qualifier word (error events only) |
| plug_i | input | 1 | Plug request for slot_i |
| unplug_i | input | 1 | Unplug request for slot_i |
| slot_i | input | 5 | Slot index for plug/unplug |
| pop_i | input | 1 | Remove the oldest event |
| have_event_o | output | 1 | Queue non-empty |
| notify_o | output | 1 | One-cycle pulse after an accepted push |
| overflow_o | output | 1 | Sticky: an event was dropped |
| rec_o | output | 208 | Oldest event as a 26-byte record, byte k at bits [8k+7:8k] |

## Verification
A wrong occupancy count appears on `have_event_o` in the cycle after the edge that caused it. It also shows up as a missed or late overflow once the queue runs near full. A corrupted read or write pointer does not show until the affected entry reaches the head, where the record comes out wrong or out of order. A wrong configured mark stays hidden until the next unplug of that slot, which then produces the wrong number of events. The bench therefore compares every output on every cycle against a behavioural model, and it drives repeated plug/unplug sequences on the same slots.

// File: rtl/fevq_pkg.sv
package fevq_pkg;

  localparam int FID_W  = 32;
  localparam int FH_W   = 32;
  localparam int CODE_W = 16;
  localparam int ADDR_W = 64;
  localparam int QUAL_W = 32;

  // Record image: byte k lives at bits [8k+7:8k], fields big-endian.
  localparam int REC_BYTES = 26;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int OFF_LEN   = 0;
  localparam int OFF_CLS   = 2;
  localparam int OFF_FID   = 4;
  localparam int OFF_FH    = 8;
  localparam int OFF_QUAL  = 12;
  localparam int OFF_ADDR  = 16;
  localparam int OFF_CODE  = 24;

  localparam logic [FH_W-1:0] FH_SLOT_FLAG = 32'h8000_0000;

  typedef enum logic [1:0] {
    EVC_NONE  = 2'd0,
    EVC_ERR   = 2'd1,
    EVC_AVAIL = 2'd2,
    EVC_RSVD  = 2'd3
  } ev_class_e;

  typedef struct packed {
    ev_class_e          cls;
    logic [FID_W-1:0]   fid;
    logic [FH_W-1:0]    fh;
    logic [CODE_W-1:0]  code;
    logic [ADDR_W-1:0]  addr;
    logic [QUAL_W-1:0]  qual;
  } ev_rec_t;

  // Place the low nbytes of val at byte offset off, most significant first.
  function automatic logic [REC_W-1:0] put_be(input logic [REC_W-1:0] img,
                                              input int off, input int nbytes,
                                              input logic [63:0] val);
    logic [REC_W-1:0] r;
    r = img;
    for (int i = 0; i < 8; i++) begin
      if (i < nbytes) r[(off+i)*8 +: 8] = val[(nbytes-1-i)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [REC_W-1:0] pack_rec(input ev_rec_t e, input logic valid);
    logic [REC_W-1:0] img;
    img = '0;
    if (valid) begin
      img = put_be(img, OFF_LEN, 2, 64'(REC_BYTES));
      img = put_be(img, OFF_CLS, 1, {62'd0, e.cls});
      img = put_be(img, OFF_FID, 4, {32'd0, e.fid});
      img = put_be(img, OFF_FH, 4, {32'd0, e.fh});
      img = put_be(img, OFF_CODE, 2, {48'd0, e.code});
      if (e.cls == EVC_ERR) begin
        img = put_be(img, OFF_QUAL, 4, {32'd0, e.qual});
        img = put_be(img, OFF_ADDR, 8, e.addr);
      end
    end
    return img;
  endfunction

  function automatic logic [FID_W-1:0] slot_fid(input int slot);
    return FID_W'(slot);
  endfunction

  function automatic logic [FH_W-1:0] slot_handle(input int slot);
    return FH_W'(slot) | FH_SLOT_FLAG;
  endfunction

endpackage

// File: rtl/fevq_plug_seq.sv
module fevq_plug_seq
  import fevq_pkg::*;
#(
  parameter int          SLOTS            = 32,
  parameter logic [15:0] CODE_RSV_TO_STBY = 16'h0301,
  parameter logic [15:0] CODE_STBY_TO_CFG = 16'h0302,
  parameter logic [15:0] CODE_CFG_TO_SR   = 16'h0303,
  parameter logic [15:0] CODE_STBY_TO_RSV = 16'h0304,
  localparam int         SLOT_W           = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plug_i,
  input  logic              unplug_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [1:0]        ev_v_o,
  output ev_rec_t [1:0]     ev_o
);

  logic [SLOTS-1:0] cfg_q;
  logic             plug_fire;
  logic             unplug_fire;
  logic             was_cfg;

  assign plug_fire   = plug_i;
  assign unplug_fire = unplug_i & ~plug_i;
  assign was_cfg     = cfg_q[slot_i];

  function automatic ev_rec_t avail_ev(input logic [SLOT_W-1:0] s, input logic [15:0] code);
    ev_rec_t e;
    e      = '0;
    e.cls  = EVC_AVAIL;
    e.fid  = slot_fid(int'(s));
    e.fh   = slot_handle(int'(s));
    e.code = code;
    return e;
  endfunction

  always_comb begin
    ev_v_o   = 2'b00;
    ev_o[0]  = avail_ev(slot_i, CODE_RSV_TO_STBY);
    ev_o[1]  = avail_ev(slot_i, CODE_STBY_TO_CFG);
    if (plug_fire) begin
      ev_v_o = 2'b11;
    end else if (unplug_fire) begin
      if (was_cfg) begin
        ev_o[0] = avail_ev(slot_i, CODE_CFG_TO_SR);
        ev_o[1] = avail_ev(slot_i, CODE_STBY_TO_RSV);
        ev_v_o  = 2'b11;
      end else begin
        ev_o[0] = avail_ev(slot_i, CODE_STBY_TO_RSV);
        ev_v_o  = 2'b01;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_q <= '0;
    else if (plug_fire)    cfg_q[slot_i] <= 1'b1;
    else if (unplug_fire)  cfg_q[slot_i] <= 1'b0;
  end

  // R7
  plug_sets_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plug_fire |=> cfg_q[$past(slot_i)]);

  // R8
  unplug_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unplug_fire |=> !cfg_q[$past(slot_i)]);

endmodule

// File: rtl/fevq_fifo.sv
module fevq_fifo
  import fevq_pkg::*;
#(
  parameter int  DEPTH = 8,
  parameter int  NW    = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      wr_v_i,
  input  ev_rec_t [NW-1:0]   wr_d_i,
  input  logic               pop_i,
  output ev_rec_t            head_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [NW-1:0]      acc_o,
  output logic               drop_o
);

  ev_rec_t          mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_eff;
  logic [CNT_W:0]   room;
  logic [CNT_W:0]   n_acc;
  logic [PTR_W-1:0] wr_idx [NW];

  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p, input int n);
    int t;
    t = int'(p) + n;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  assign pop_eff = pop_i && (cnt_q != '0);
  assign room    = (CNT_W+1)'(DEPTH) - {1'b0, cnt_q} + {{CNT_W{1'b0}}, pop_eff};

  // Ports are served in index order, each taking the next free entry.
  always_comb begin
    n_acc = '0;
    for (int k = 0; k < NW; k++) begin
      wr_idx[k] = ring_add(wp_q, int'(n_acc));
      acc_o[k]  = wr_v_i[k] && (n_acc < room);
      n_acc     = n_acc + {{CNT_W{1'b0}}, acc_o[k]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= ring_add(wp_q, int'(n_acc));
      if (pop_eff) rp_q <= ring_add(rp_q, 1);
      cnt_q <= CNT_W'({1'b0, cnt_q} + n_acc - {{CNT_W{1'b0}}, pop_eff});
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NW; k++) begin
      if (acc_o[k]) mem[wr_idx[k]] <= wr_d_i[k];
    end
  end

  assign head_o  = mem[rp_q];
  assign count_o = cnt_q;
  assign drop_o  = |(wr_v_i & ~acc_o);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> {1'b0, cnt_q} == $past({1'b0, cnt_q}) + $past(n_acc) - $past({{CNT_W{1'b0}}, pop_eff}));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && wr_v_i == '0) |=> (cnt_q == '0 && $stable(rp_q)));

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && !pop_i) |=> cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/fevq_rec_pack.sv
module fevq_rec_pack
  import fevq_pkg::*;
(
  input  ev_rec_t          ev_i,
  input  logic             valid_i,
  output logic [REC_W-1:0] rec_o
);

  always_comb rec_o = pack_rec(ev_i, valid_i);

endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
  import fevq_pkg::*;
#(
  parameter int  SLOTS  = 32,
  parameter int  DEPTH  = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [1:0]        push_class_i,
  input  logic [FID_W-1:0]  push_fid_i,
  input  logic [FH_W-1:0]   push_fh_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [QUAL_W-1:0] push_qual_i,
  input  logic              plug_i,
  input  logic              unplug_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pop_i,
  output logic              have_event_o,
  output logic              notify_o,
  output logic              overflow_o,
  output logic [REC_W-1:0]  rec_o
);

  localparam int NW    = 3;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]        seq_v;
  ev_rec_t [1:0]     seq_ev;
  logic              ext_v;
  ev_rec_t           ext_ev;
  logic [NW-1:0]     wr_v;
  ev_rec_t [NW-1:0]  wr_d;
  logic [NW-1:0]     acc;
  logic              drop;
  ev_rec_t           head;
  logic [CNT_W-1:0]  count;
  logic              notify_q;
  logic              ovf_q;

  fevq_plug_seq #(.SLOTS(SLOTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .plug_i   (plug_i),
    .unplug_i (unplug_i),
    .slot_i   (slot_i),
    .ev_v_o   (seq_v),
    .ev_o     (seq_ev)
  );

  assign ext_v = push_i && ((push_class_i == EVC_ERR) || (push_class_i == EVC_AVAIL));

  always_comb begin
    ext_ev      = '0;
    ext_ev.cls  = ev_class_e'(push_class_i);
    ext_ev.fid  = push_fid_i;
    ext_ev.fh   = push_fh_i;
    ext_ev.code = push_code_i;
    ext_ev.addr = push_addr_i;
    ext_ev.qual = push_qual_i;
  end

  // Sequencer events take the lower port indices and are served first.
  assign wr_v = {ext_v, seq_v};
  assign wr_d = {ext_ev, seq_ev};

  fevq_fifo #(.DEPTH(DEPTH), .NW(NW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_v_i  (wr_v),
    .wr_d_i  (wr_d),
    .pop_i   (pop_i),
    .head_o  (head),
    .count_o (count),
    .acc_o   (acc),
    .drop_o  (drop)
  );

  fevq_rec_pack u_pack (
    .ev_i    (head),
    .valid_i (have_event_o),
    .rec_o   (rec_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      notify_q <= |acc;
      ovf_q    <= ovf_q | drop;
    end
  end

  assign have_event_o = (count != '0);
  assign notify_o     = notify_q;
  assign overflow_o   = ovf_q;

  // R6
  notify_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc) |=> notify_o);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R5
  pending_has_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_event_o |-> (rec_o[OFF_CLS*8 +: 8] != 8'h00));

endmodule

// File: tb/fn_event_queue_tb.sv
`timescale 1ns/1ps
module fn_event_queue_tb_top;

  localparam int SLOTS = 32;
  localparam int DEPTH = 8;
  localparam int RB    = 26;
  localparam logic [15:0] C_RS = 16'h0301;
  localparam logic [15:0] C_SC = 16'h0302;
  localparam logic [15:0] C_CX = 16'h0303;
  localparam logic [15:0] C_SR = 16'h0304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        push_i = 0;
  logic [1:0]  push_class_i = 0;
  logic [31:0] push_fid_i = 0;
  logic [31:0] push_fh_i = 0;
  logic [15:0] push_code_i = 0;
  logic [63:0] push_addr_i = 0;
  logic [31:0] push_qual_i = 0;
  logic        plug_i = 0;
  logic        unplug_i = 0;
  logic [4:0]  slot_i = 0;
  logic        pop_i = 0;
  logic        have_event_o, notify_o, overflow_o;
  logic [RB*8-1:0] rec_o;

  fn_event_queue dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_class_i(push_class_i),
    .push_fid_i(push_fid_i), .push_fh_i(push_fh_i), .push_code_i(push_code_i),
    .push_addr_i(push_addr_i), .push_qual_i(push_qual_i), .plug_i(plug_i),
    .unplug_i(unplug_i), .slot_i(slot_i), .pop_i(pop_i),
    .have_event_o(have_event_o), .notify_o(notify_o), .overflow_o(overflow_o),
    .rec_o(rec_o)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic [31:0] fid;
    logic [31:0] fh;
    logic [15:0] code;
    logic [63:0] addr;
    logic [31:0] qual;
  } mrec_t;

  mrec_t       mq[$];
  logic [31:0] mcfg;
  bit          m_notify;
  bit          m_ovf;
  int          checks = 0;
  int          errors = 0;
  string       tag = "R13";
  bit          done = 0;

  function automatic logic [RB*8-1:0] mpack(input mrec_t r, input bit valid);
    logic [7:0] b [RB];
    logic [RB*8-1:0] img;
    for (int i = 0; i < RB; i++) b[i] = 8'h00;
    if (valid) begin
      b[1] = 8'd26;
      b[2] = {6'd0, r.cls};
      for (int i = 0; i < 4; i++) begin
        b[4+i] = r.fid[31-8*i -: 8];
        b[8+i] = r.fh[31-8*i -: 8];
      end
      if (r.cls == 2'd1) begin
        for (int i = 0; i < 4; i++) b[12+i] = r.qual[31-8*i -: 8];
        for (int i = 0; i < 8; i++) b[16+i] = r.addr[63-8*i -: 8];
      end
      b[24] = r.code[15:8];
      b[25] = r.code[7:0];
    end
    for (int i = 0; i < RB; i++) img[i*8 +: 8] = b[i];
    return img;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [RB*8-1:0] act, input logic [RB*8-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [RB*8-1:0] er;
    bit ne;
    ne = (mq.size() > 0);
    er = mpack(ne ? mq[0] : mrec_t'(0), ne);
    chk(have_event_o === ne, "R5", "have_event", RB*8'(have_event_o), RB*8'(ne));
    chk(notify_o === m_notify, "R6", "notify", RB*8'(notify_o), RB*8'(m_notify));
    chk(overflow_o === m_ovf, "R10", "overflow", RB*8'(overflow_o), RB*8'(m_ovf));
    chk(rec_o === er, tag, "record", rec_o, er);
    if (ne) chk(rec_o[31:0] === {8'h00, mpack(mq[0], 1'b1)[23:16], 16'h1A00},
                "R9", "length", RB*8'(rec_o[31:0]), RB*8'(32'h1A00));
  endtask

  task automatic model_step();
    mrec_t c[$];
    mrec_t e;
    m_notify = 0;
    if (pop_i && mq.size() > 0) void'(mq.pop_front());
    e = '0;
    e.cls = 2'd2;
    e.fid = 32'(slot_i);
    e.fh  = 32'(slot_i) | 32'h8000_0000;
    if (plug_i) begin
      e.code = C_RS; c.push_back(e);
      e.code = C_SC; c.push_back(e);
      mcfg[slot_i] = 1'b1;
    end else if (unplug_i) begin
      if (mcfg[slot_i]) begin
        e.code = C_CX; c.push_back(e);
        mcfg[slot_i] = 1'b0;
      end
      e.code = C_SR; c.push_back(e);
    end
    if (push_i && (push_class_i == 2'd1 || push_class_i == 2'd2)) begin
      e = {push_class_i, push_fid_i, push_fh_i, push_code_i, push_addr_i, push_qual_i};
      c.push_back(e);
    end
    foreach (c[i]) begin
      if (mq.size() < DEPTH) begin
        mq.push_back(c[i]);
        m_notify = 1;
      end else begin
        m_ovf = 1;
      end
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
    push_i = 0; plug_i = 0; unplug_i = 0; pop_i = 0;
  endtask

  task automatic set_push(input logic [1:0] cls, input logic [31:0] fid, input logic [31:0] fh,
                          input logic [15:0] code, input logic [63:0] addr, input logic [31:0] qual);
    push_i = 1; push_class_i = cls; push_fid_i = fid; push_fh_i = fh;
    push_code_i = code; push_addr_i = addr; push_qual_i = qual;
  endtask

  task automatic do_reset();
    rst_n = 0;
    mq.delete(); mcfg = '0; m_notify = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R13";
    compare();
  endtask

  initial begin
    #(8.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    repeat (2) cyc();

    // R2: error records, several patterns
    tag = "R2";
    set_push(2'd1, 32'h1122_3344, 32'h8000_0005, 16'hBEEF, 64'h0102_0304_0506_0708, 32'hA5A5_0F0F); cyc();
    set_push(2'd1, 32'hFFFF_FFFF, 32'h0, 16'h0001, 64'hFFFF_0000_FFFF_0000, 32'h0000_0001); cyc();
    set_push(2'd1, 32'h0, 32'hDEAD_BEEF, 16'h8000, 64'h8000_0000_0000_0001, 32'h8000_0000); cyc();
    tag = "R4";
    repeat (3) begin pop_i = 1; cyc(); end

    // R3: availability record with non-zero address/qualifier inputs
    tag = "R3";
    set_push(2'd2, 32'h0000_0042, 32'h8000_0042, 16'h0123, 64'hCAFE_CAFE_CAFE_CAFE, 32'h1234_5678); cyc();
    pop_i = 1; cyc();

    // R1: class 0 and class 3 pushes are ignored
    tag = "R1";
    set_push(2'd0, 32'h5, 32'h5, 16'h5, 64'h5, 32'h5); cyc();
    set_push(2'd3, 32'h6, 32'h6, 16'h6, 64'h6, 32'h6); cyc();
    cyc();

    // R4: interleaved pushes and pops, including same-cycle
    tag = "R4";
    for (int i = 0; i < 12; i++) begin
      set_push((i % 3 == 0) ? 2'd2 : 2'd1, 32'(i), 32'(i * 7), 16'(i + 100), 64'(i) << 40, 32'(i * 3));
      pop_i = (i % 2 == 1);
      cyc();
    end
    while (mq.size() > 0) begin pop_i = 1; cyc(); end

    // R7: plug sequences
    tag = "R7";
    slot_i = 5'd5; plug_i = 1; cyc();
    slot_i = 5'd31; plug_i = 1; cyc();
    repeat (4) begin pop_i = 1; cyc(); end

    // R8: unplug configured slot, then a never-plugged slot
    tag = "R8";
    slot_i = 5'd5; unplug_i = 1; cyc();
    slot_i = 5'd9; unplug_i = 1; cyc();
    slot_i = 5'd5; unplug_i = 1; cyc();
    while (mq.size() > 0) begin pop_i = 1; cyc(); end

    // R12: plug and unplug together plus an external push
    tag = "R12";
    slot_i = 5'd7; plug_i = 1; unplug_i = 1;
    set_push(2'd1, 32'h77, 32'h77, 16'h7777, 64'h77, 32'h77); cyc();
    slot_i = 5'd7; unplug_i = 1;
    set_push(2'd2, 32'h78, 32'h78, 16'h7878, 64'h0, 32'h0); cyc();
    while (mq.size() > 0) begin pop_i = 1; cyc(); end

    // R10: fill to overflow, then push+pop at full, then partial room for a plug
    tag = "R10";
    for (int i = 0; i < DEPTH + 2; i++) begin
      set_push(2'd1, 32'(200 + i), 32'(i), 16'(i), 64'(i), 32'(i)); cyc();
    end
    tag = "R4";
    pop_i = 1; set_push(2'd2, 32'h300, 32'h301, 16'h302, 64'h0, 32'h0); cyc();
    pop_i = 1; cyc();
    tag = "R10";
    slot_i = 5'd12; plug_i = 1; cyc();
    while (mq.size() > 0) begin pop_i = 1; cyc(); end

    // R11: pops on an empty queue
    tag = "R11";
    repeat (3) begin pop_i = 1; cyc(); end

    // R4: mixed random traffic
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) != 0)
        set_push(2'($urandom_range(0, 3)), $urandom, $urandom, 16'($urandom),
                 {$urandom, $urandom}, $urandom);
      slot_i = 5'($urandom_range(0, 3));
      plug_i = ($urandom_range(0, 7) == 0);
      unplug_i = ($urandom_range(0, 7) == 0);
      pop_i = ($urandom_range(0, 1) == 1);
      cyc();
    end

    // R13: reset in mid-run clears queue, flags and configured marks
    do_reset();
    cyc();
    tag = "R8";
    slot_i = 5'd1; unplug_i = 1; cyc();
    pop_i = 1; cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule